// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This block keeps the interrupt event flags of a packet network controller and drives a level-sensitive, active-low interrupt line to the host. Single-cycle event pulses arrive from the receive and transmit descriptor paths and from the initialization sequencer. A fourth flag, the memory error, is raised inside the block by a watchdog that measures how long a bus request has waited for its grant, in units of a prescaled microsecond tick.

The host reaches four 16-bit registers through a simple write strobe with a combinational read port. They hold the write-one-to-clear flags, the global enable, a stop strobe, the per-flag masks, the look-ahead receive option, the successful-transmit suppression option and the bus timeout limit. The block reports a summary interrupt bit, which does not depend on the global enable, and an error summary bit, which depends on neither the masks nor the enable. An external system or sleep interrupt level drives the pin without regard to the enable.

Top module: `nic_irq_status`

## Requirements
- R1: The flags sit in register 0 at bits 11 (memory error), 10 (receive), 9 (transmit) and 8 (init done). A register 0 write with a 1 in a flag bit clears that flag. A 0 in that bit leaves it unchanged.
- R2: All four flags go to 0 on hard reset (`rst_n` low), on a `soft_rst` pulse, and on a register 0 write with bit 2 (stop) set. Stop always reads back as 0.
- R3: `irq_n` is low exactly when `sys_irq` is 1, or when the global enable (register 0 bit 6, read/write) is 1 and some flag is set whose mask bit is 0. Mask bits sit in register 1 at bits 11..8, in the same order as the flags.
- R4: Register 0 bit 15 reads 1 whenever the memory-error flag is set, whatever the masks and the global enable hold.
- R5: While `bus_req` is 1 and `bus_gnt` is 0, a prescaler produces one tick every PRESCALE cycles. The memory-error flag becomes visible after exactly PRESCALE×L consecutive such cycles, where L is register 3 and is nonzero. Dropping the request or seeing a grant restarts the count. A request fires at most once. L = 0 never fires.
- R6: A `rx_desc_done` pulse with `rx_last` set sets the receive flag. With `rx_first` set, the pulse also sets it when the look-ahead bit (register 1 bit 5) is 1.
- R7: A `tx_desc_done` pulse with `tx_last` set sets the transmit flag. It does not do so when the suppression bit (register 2 bit 15) is 1 and `tx_ok` is 1.
- R8: Register 0 bit 7 reads 1 when some flag is set with its mask bit 0, or when `sys_irq` is 1, independent of the global enable.
- R9: If an event that sets a flag and a host write of 1 to that flag occur in the same cycle, the flag is set afterwards. A stop or soft reset in the same cycle as the event clears the flag instead.
- R10: After hard reset, registers 0, 1 and 2 read 0, register 3 reads TO_DEFAULT, and `irq_n` is 1. Register writes take effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset pulse; clears flags and the timeout state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| rx_desc_done | input | 1 | Receive descriptor ownership released (pulse) |
| rx_first | input | 1 | Qualifier: released descriptor is the first of a frame |
| rx_last | input | 1 | Qualifier: released descriptor is the last of a frame |
| tx_desc_done | input | 1 | Transmit descriptor ownership released (pulse) |
| tx_last | input | 1 | Qualifier: released descriptor is the last of a frame |
| tx_ok | input | 1 | Qualifier: frame was sent without error |
| init_done | input | 1 | Initialization sequence finished (pulse) |
| bus_req | input | 1 | Bus request level |
| bus_gnt | input | 1 | Bus grant level |
| sys_irq | input | 1 | System/sleep interrupt level; drives the pin regardless of the enable |
| irq_n | output | 1 | Interrupt output, active low, level |

## Verification
The assertions assume that the event inputs are single-cycle pulses whose qualifiers are valid in the same cycle. They also assume that a flag the host clears is not raised by an event in the same cycle, unless that case is the point of the test. The stimulus drives every input away from the clock edge. It keeps `soft_rst` rare so that the flags can build up. It gives `bus_gnt` a low probability and the timeout limit a small value, so that the watchdog both fires and restarts many times within the run. A bench model updated on the same edges predicts every read value and the interrupt pin.

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
  parameter int TO_W       = 16,
  parameter int PRESCALE   = 125,
  parameter int TO_DEFAULT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rx_desc_done,
  input  logic        rx_first,
  input  logic        rx_last,
  input  logic        tx_desc_done,
  input  logic        tx_last,
  input  logic        tx_ok,
  input  logic        init_done,
  input  logic        bus_req,
  input  logic        bus_gnt,
  input  logic        sys_irq,
  output logic        irq_n
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [3:0]      flags, mask, set_v, clr_v;
  logic            ien, look_ahead, tx_ok_quiet, fired;
  logic [TO_W-1:0] limit, us, us_nx;
  logic [PW-1:0]   pre;

  wire wr0      = reg_wr && (reg_addr == 2'd0);
  wire stop     = wr0 && reg_wdata[2];
  wire waiting  = bus_req && !bus_gnt;
  wire tick     = waiting && !fired && (pre == PRE_LAST);
  assign us_nx  = us + 1'b1;
  wire timeout  = tick && (limit != '0) && (us_nx == limit);

  wire rx_set   = rx_desc_done && (rx_last || (rx_first && look_ahead));
  wire tx_set   = tx_desc_done && tx_last && !(tx_ok_quiet && tx_ok);
  assign set_v  = {timeout, rx_set, tx_set, init_done};
  assign clr_v  = wr0 ? reg_wdata[11:8] : 4'b0;

  wire pending  = |(flags & ~mask);
  wire summary  = pending || sys_irq;
  assign irq_n  = !((ien && pending) || sys_irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flags <= '0;
    else if (soft_rst || stop) flags <= '0;
    else                       flags <= (flags & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien         <= 1'b0;
      mask        <= '0;
      look_ahead  <= 1'b0;
      tx_ok_quiet <= 1'b0;
      limit       <= TO_W'(TO_DEFAULT);
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: ien <= reg_wdata[6];
        2'd1: begin
          mask       <= reg_wdata[11:8];
          look_ahead <= reg_wdata[5];
        end
        2'd2: tx_ok_quiet <= reg_wdata[15];
        default: limit <= reg_wdata[TO_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; us <= '0; fired <= 1'b0;
    end else if (soft_rst || !waiting) begin
      pre <= '0; us <= '0; fired <= 1'b0;
    end else if (tick) begin
      pre   <= '0;
      us    <= us_nx;
      fired <= timeout;
    end else if (!fired) begin
      pre <= pre + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {flags[3], 3'b0, flags, summary, ien, 6'b0};
      2'd1:    reg_rdata = {4'b0, mask, 2'b0, look_ahead, 5'b0};
      2'd2:    reg_rdata = {tx_ok_quiet, 15'b0};
      default: reg_rdata = 16'(limit);
    endcase
  end
endmodule

module nic_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        rx_desc_done,
  input logic        rx_last,
  input logic        init_done,
  input logic        bus_req,
  input logic        bus_gnt,
  input logic        sys_irq,
  input logic        irq_n,
  input logic        ien,
  input logic [3:0]  flags
);
  wire w0   = reg_wr && (reg_addr == 2'd0);
  wire stp  = w0 && reg_wdata[2];

  p_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (w0 && reg_wdata[8] && !init_done) |=> !flags[0]);

  p_soft_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags == 4'b0));

  p_pin_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (sys_irq || ien));

  p_merr_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> $past(bus_req && !bus_gnt));

  p_rx_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_desc_done && rx_last && !soft_rst && !stp) |=> flags[2]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !soft_rst && !stp) |=> flags[0]);
endmodule

bind nic_irq_status nic_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rx_desc_done(rx_desc_done),
  .rx_last(rx_last), .init_done(init_done), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .sys_irq(sys_irq), .irq_n(irq_n), .ien(ien),
  .flags(flags)
);

// File: tb/test_nic_irq_status.sv
module test_nic_irq_status;
  localparam int PRE = 4;
  localparam int DEF = 1000;

  logic clk = 0, rst_n = 0, soft_rst = 0, reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic rx_desc_done = 0, rx_first = 0, rx_last = 0;
  logic tx_desc_done = 0, tx_last = 0, tx_ok = 0, init_done = 0;
  logic bus_req = 0, bus_gnt = 0, sys_irq = 0, irq_n;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  nic_irq_status #(.TO_W(16), .PRESCALE(PRE), .TO_DEFAULT(DEF)) i_nic_irq_status (.*);

  logic [3:0]  m_flags, m_mask;
  logic        m_ien, m_la, m_quiet, m_fired;
  logic [15:0] m_limit, m_us;
  int          m_pre;

  function automatic logic [15:0] m_read(logic [1:0] a);
    logic pend = |(m_flags & ~m_mask);
    case (a)
      2'd0: return {m_flags[3], 3'b0, m_flags, pend | sys_irq, m_ien, 6'b0};
      2'd1: return {4'b0, m_mask, 2'b0, m_la, 5'b0};
      2'd2: return {m_quiet, 15'b0};
      default: return m_limit;
    endcase
  endfunction

  function automatic logic m_irq_n();
    return !((m_ien && |(m_flags & ~m_mask)) || sys_irq);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_flags = 0; m_mask = 0; m_ien = 0; m_la = 0; m_quiet = 0;
    m_limit = DEF; m_us = 0; m_pre = 0; m_fired = 0;
  endtask

  task automatic cyc(string tag = "R8");
    logic [3:0] set_v, clr_v, nf;
    logic w0 = reg_wr && reg_addr == 0;
    logic stp = w0 && reg_wdata[2];
    logic tmo = 0;
    int np = m_pre; logic [15:0] nu = m_us; logic nfi = m_fired;
    if (soft_rst || !(bus_req && !bus_gnt)) begin np = 0; nu = 0; nfi = 0; end
    else if (!m_fired) begin
      if (m_pre == PRE - 1) begin
        np = 0; nu = m_us + 1;
        tmo = (m_limit != 0) && (nu == m_limit);
        nfi = tmo;
      end else np = m_pre + 1;
    end
    set_v = {tmo, rx_desc_done && (rx_last || (rx_first && m_la)),
             tx_desc_done && tx_last && !(m_quiet && tx_ok), init_done};
    clr_v = w0 ? reg_wdata[11:8] : 4'b0;
    nf = (soft_rst || stp) ? 4'b0 : ((m_flags & ~clr_v) | set_v);
    @(posedge clk);
    m_flags = nf; m_pre = np; m_us = nu; m_fired = nfi;
    if (reg_wr) case (reg_addr)
      2'd0: m_ien = reg_wdata[6];
      2'd1: begin m_mask = reg_wdata[11:8]; m_la = reg_wdata[5]; end
      2'd2: m_quiet = reg_wdata[15];
      default: m_limit = reg_wdata;
    endcase
    @(negedge clk);
    chk("R3", irq_n, m_irq_n());
    chk(tag, reg_rdata, m_read(reg_addr));
  endtask

  task automatic idle();
    reg_wr = 0; soft_rst = 0; rx_desc_done = 0; tx_desc_done = 0; init_done = 0;
    rx_first = 0; rx_last = 0; tx_last = 0; tx_ok = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d, string tag = "R10");
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(tag); idle(); reg_addr = 0;
  endtask

  task automatic run(int n, string tag = "R8");
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_addr = 0; #1 chk("R10", reg_rdata, 0); chk("R10", irq_n, 1);
    reg_addr = 3; #1 chk("R10", reg_rdata, DEF);
    reg_addr = 0;

    // R1: write-one-to-clear; zero leaves the flag alone
    wr(0, 16'h0040);
    init_done = 1; cyc("R1"); idle();
    chk("R1", reg_rdata[8], 1); chk("R3", irq_n, 0);
    wr(0, 16'h0040, "R1"); chk("R1", reg_rdata[8], 1);
    wr(0, 16'h0140, "R1"); chk("R1", reg_rdata[8], 0); chk("R3", irq_n, 1);

    // R6: receive set rules
    rx_desc_done = 1; rx_first = 1; cyc("R6"); idle(); chk("R6", reg_rdata[10], 0);
    wr(1, 16'h0020);
    rx_desc_done = 1; rx_first = 1; cyc("R6"); idle(); chk("R6", reg_rdata[10], 1);
    wr(0, 16'h0440, "R6"); chk("R6", reg_rdata[10], 0);
    rx_desc_done = 1; rx_last = 1; cyc("R6"); idle(); chk("R6", reg_rdata[10], 1);
    wr(0, 16'h0440);

    // R7: transmit set rules and suppression of good frames
    wr(2, 16'h8000);
    tx_desc_done = 1; tx_last = 1; tx_ok = 1; cyc("R7"); idle(); chk("R7", reg_rdata[9], 0);
    tx_desc_done = 1; tx_last = 1; cyc("R7"); idle(); chk("R7", reg_rdata[9], 1);
    wr(0, 16'h0240); wr(2, 16'h0000);
    tx_desc_done = 1; tx_last = 1; tx_ok = 1; cyc("R7"); idle(); chk("R7", reg_rdata[9], 1);

    // R3 / R8: masking, enable and bypass source
    wr(1, 16'h0200); chk("R3", irq_n, 1);
    reg_addr = 0; #1 chk("R8", reg_rdata[7], 0); chk("R1", reg_rdata[9], 1);
    wr(1, 16'h0000); chk("R3", irq_n, 0);
    wr(0, 16'h0000); chk("R3", irq_n, 1); chk("R8", reg_rdata[7], 1);
    sys_irq = 1; cyc("R8"); chk("R3", irq_n, 0); sys_irq = 0;
    wr(0, 16'h0240);

    // R5 / R4: exact timeout, restart, once per request
    wr(3, 16'd3); wr(1, 16'h0800); wr(0, 16'h0000);
    bus_req = 1; run(11, "R5"); chk("R5", reg_rdata[11], 0);
    cyc("R5"); chk("R5", reg_rdata[11], 1); chk("R4", reg_rdata[15], 1);
    chk("R3", irq_n, 1);
    run(20, "R5"); wr(0, 16'h0800, "R5"); run(20, "R5"); chk("R5", reg_rdata[11], 0);
    bus_req = 0; cyc(); bus_req = 1; run(8, "R5");
    bus_gnt = 1; cyc(); bus_gnt = 0; run(11, "R5"); chk("R5", reg_rdata[11], 0);
    cyc("R5"); chk("R5", reg_rdata[11], 1);
    bus_req = 0; wr(0, 16'h0800); wr(3, 16'd0);
    bus_req = 1; run(40, "R5"); chk("R5", reg_rdata[11], 0); bus_req = 0;

    // R9: event and clear in one cycle
    init_done = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0100; cyc("R9"); idle();
    chk("R9", reg_rdata[8], 1);
    init_done = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0004; cyc("R9"); idle();
    chk("R9", reg_rdata[8], 0);

    // R2: soft reset and stop
    init_done = 1; rx_desc_done = 1; rx_last = 1; cyc("R2"); idle();
    chk("R2", reg_rdata[10:8], 3'b101);
    soft_rst = 1; cyc("R2"); idle(); chk("R2", reg_rdata[11:8], 0);
    init_done = 1; cyc("R2"); idle();
    wr(0, 16'h0004, "R2"); chk("R2", reg_rdata[11:8], 0); chk("R2", reg_rdata[2], 0);

    // random phase
    wr(3, 16'd2);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      idle();
      rx_desc_done = ($urandom_range(0, 9) == 0); rx_first = $urandom; rx_last = $urandom;
      tx_desc_done = ($urandom_range(0, 9) == 0); tx_last = $urandom; tx_ok = $urandom;
      init_done = ($urandom_range(0, 19) == 0);
      soft_rst = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 19) == 0) bus_req = ~bus_req;
      bus_gnt = ($urandom_range(0, 29) == 0);
      sys_irq = ($urandom_range(0, 15) == 0);
      reg_addr = 2'($urandom);
      if (r < 12) begin
        reg_wr = 1;
        reg_wdata = 16'($urandom);
        if (reg_addr == 3) reg_wdata = 16'($urandom_range(0, 5));
        if (reg_addr == 0 && $urandom_range(0, 3) != 0) reg_wdata[2] = 0;
      end
      cyc("R8");
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule